// File: doc/BRIEF.md
# DRAM Chip-Select Window Decoder

This block holds the address windows of up to four DRAM chip selects. It answers, one clock after a lookup request, whether a 32-bit physical address falls inside one of them. Software programs each window through a small 32-bit register port. Each window has two words:

- a placement word that carries address bits 31:24 and 35:32;
- an extent word that carries an enable, a chip-select number and the window length in 16 MB granules.

A DMA master that wants to reach memory asks the decoder with an address. The decoder replies with three things:

- hit;
- the index of the window that matched;
- the 8-bit bus attribute the master must present. This is an active-low chip-select mask in bits 3:0, and bit 4 is raised when hardware I/O coherency is on.

The target identifier for DRAM is always zero. Only windows that are enabled and lie entirely below 4 GB can match. The decoder also publishes which windows are usable, as a mask and as a count, so that agents can see the window list without reading the registers.

Top module: `dram_cs_decoder`

## Requirements
- R1: Register map by byte offset (bits 1:0 ignored). The placement word of window n is at 8·n and the extent word is at 8·n+4. Writes at offsets 0x20 and above change nothing, and reads there return 0. Read data appears on `reg_rdata` the cycle after `reg_rd`.
- R2: The placement word keeps bits 31:24 and 3:0. The extent word keeps bits 31:24, 4:2 and 0. All other bits read back as 0.
- R3: Reset clears every register, so every window is disabled. After reset, `elig_cnt` is 0, `elig_mask` is 0 and no lookup hits.
- R4: A window is eligible only when extent bit 0 is 1 and placement bits 3:0 are all 0. An ineligible window never produces a hit.
- R5: The window start is {placement[31:24], 24'h0}. The length is (extent[31:24]+1)·16 MB. An address hits when start ≤ address ≤ start+length−1, and this holds up to the 4 GB boundary.
- R6: When several eligible windows contain the address, the lowest window index wins.
- R7: On a hit for window i, `lk_attr` is 0x0F with bit i cleared. Bit 4 (0x10) is also set when `coh_en` was high in the request cycle.
- R8: When no eligible window matches, `lk_hit`, `lk_cs` and `lk_attr` are 0. `lk_target` is 0 at all times.
- R9: The lookup result is registered. It reflects the request presented in the previous cycle, and a cycle without `lk_valid` yields no hit.
- R10: `elig_mask` (bit i = window i eligible) and `elig_cnt` (its population count) take their new value one cycle after the register write lands, that is two clock edges after the write is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coh_en | input | 1 | Hardware coherency enable, adds attribute bit 4 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Lookup physical address |
| lk_hit | output | 1 | Address matched an eligible window |
| lk_cs | output | 2 | Index of the matching window |
| lk_attr | output | 8 | Bus attribute for the matching chip select |
| lk_target | output | 4 | DRAM target identifier (always 0) |
| elig_cnt | output | 3 | Number of eligible windows |
| elig_mask | output | 4 | Eligible windows, bit per window |

## Verification
The hardest case to reach is an address that lies inside more than one eligible window while also sitting on an exact window edge. This needs overlapping windows and addresses at the first and last byte of each. Random programming alone almost never lines these up. The stimulus therefore draws small granule counts and few distinct start values, so that windows overlap often. It then picks lookup addresses from each window's start, its last byte and the byte after it. Directed cases add a window ending at the 4 GB boundary, and a window that is enabled but carries high placement bits.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef struct packed {
    logic [7:0] base_lo;   // address bits 31:24
    logic [3:0] base_hi;   // address bits 35:32
    logic [7:0] gran_m1;   // length in 16 MB granules minus one
    logic [2:0] cs_num;    // chip-select number field (stored only)
    logic       en;
  } win_cfg_t;

  localparam int GRAN_SHIFT = 24;

  // first byte of a window, 33 bits wide so the top window cannot wrap
  function automatic logic [32:0] win_first(input win_cfg_t c);
    return {1'b0, c.base_lo, 24'h0};
  endfunction

  // last byte of a window: start plus (length-1), lower bits all ones
  function automatic logic [32:0] win_last(input win_cfg_t c);
    return {1'b0, c.base_lo, 24'h0} + {1'b0, c.gran_m1, 24'hFF_FFFF};
  endfunction

  function automatic logic win_usable(input win_cfg_t c);
    return c.en && (c.base_hi == 4'h0);
  endfunction

  // active-low chip-select mask, plus coherency flag
  function automatic logic [7:0] cs_attr(input logic [2:0] idx, input logic coh);
    logic [7:0] a;
    a = 8'h0F & ~(8'h01 << idx);
    if (coh) a = a | 8'h10;
    return a;
  endfunction

  function automatic logic [31:0] pack_place(input win_cfg_t c);
    return {c.base_lo, 20'h0, c.base_hi};
  endfunction

  function automatic logic [31:0] pack_extent(input win_cfg_t c);
    return {c.gran_m1, 19'h0, c.cs_num, 1'b0, c.en};
  endfunction

endpackage

// File: rtl/dcd_win_regs.sv
module dcd_win_regs
  import dcd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int RAW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic                      rd,
  input  logic [RAW-1:0]            addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output win_cfg_t [NUM_WIN-1:0]    cfg
);
  localparam int WORDS = 2 * NUM_WIN;
  localparam int WW    = RAW - 2;

  logic [WW-1:0] word;
  logic          in_map;

  assign word   = addr[RAW-1:2];
  assign in_map = (int'(word) < WORDS);

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic wr_place, wr_extent;
    assign wr_place  = wr && in_map && (int'(word) == 2 * i);
    assign wr_extent = wr && in_map && (int'(word) == 2 * i + 1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i] <= '0;
      end else begin
        if (wr_place) begin
          cfg[i].base_lo <= wdata[31:24];
          cfg[i].base_hi <= wdata[3:0];
        end
        if (wr_extent) begin
          cfg[i].gran_m1 <= wdata[31:24];
          cfg[i].cs_num  <= wdata[4:2];
          cfg[i].en      <= wdata[0];
        end
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (in_map && int'(word) == 2 * i)     rd_mux = pack_place(cfg[i]);
      if (in_map && int'(word) == 2 * i + 1) rd_mux = pack_extent(cfg[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

endmodule

// File: rtl/dcd_match.sv
module dcd_match
  import dcd_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  win_cfg_t [NUM_WIN-1:0] cfg,
  input  logic [31:0]            addr,
  output logic [NUM_WIN-1:0]     usable,
  output logic [NUM_WIN-1:0]     hit_vec
);
  logic [32:0] a33;
  assign a33 = {1'b0, addr};

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic above, below;
    assign usable[i]  = win_usable(cfg[i]);
    assign above      = (a33 >= win_first(cfg[i]));
    assign below      = (a33 <= win_last(cfg[i]));
    assign hit_vec[i] = usable[i] && above && below;
  end

endmodule

// File: rtl/dcd_select.sv
module dcd_select
  import dcd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               coh,
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output logic [7:0]         attr
);
  logic             any;
  logic [IDX_W-1:0] pick;

  // lowest index wins
  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any  = 1'b1;
        pick = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit  <= 1'b0;
      idx  <= '0;
      attr <= '0;
    end else if (req && any) begin
      hit  <= 1'b1;
      idx  <= pick;
      attr <= cs_attr(3'(pick), coh);
    end else begin
      hit  <= 1'b0;
      idx  <= '0;
      attr <= '0;
    end
  end

endmodule

// File: rtl/dram_cs_decoder.sv
module dram_cs_decoder
  import dcd_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int REG_AW    = 8,
  parameter int TARGET_ID = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          coh_en,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          lk_valid,
  input  logic [31:0]                   lk_addr,
  output logic                          lk_hit,
  output logic [$clog2(NUM_WIN)-1:0]    lk_cs,
  output logic [7:0]                    lk_attr,
  output logic [3:0]                    lk_target,
  output logic [$clog2(NUM_WIN+1)-1:0]  elig_cnt,
  output logic [NUM_WIN-1:0]            elig_mask
);
  localparam int IDX_W = $clog2(NUM_WIN);
  localparam int CNT_W = $clog2(NUM_WIN + 1);

  win_cfg_t [NUM_WIN-1:0] cfg;
  logic [NUM_WIN-1:0]     usable_now;
  logic [NUM_WIN-1:0]     hit_vec;

  dcd_win_regs #(.NUM_WIN(NUM_WIN), .RAW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  dcd_match #(.NUM_WIN(NUM_WIN)) u_match (
    .cfg(cfg), .addr(lk_addr), .usable(usable_now), .hit_vec(hit_vec)
  );

  dcd_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(lk_valid), .coh(coh_en), .hit_vec(hit_vec),
    .hit(lk_hit), .idx(lk_cs), .attr(lk_attr)
  );

  logic [CNT_W-1:0] cnt_now;
  always_comb begin
    cnt_now = '0;
    for (int i = 0; i < NUM_WIN; i++) cnt_now = cnt_now + CNT_W'(usable_now[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elig_mask <= '0;
      elig_cnt  <= '0;
    end else begin
      elig_mask <= usable_now;
      elig_cnt  <= cnt_now;
    end
  end

  assign lk_target = 4'(TARGET_ID);

endmodule

// File: rtl/dram_cs_decoder_chk.sv
module dram_cs_decoder_chk #(
  parameter int NUM_WIN = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         reg_wr,
  input logic                         lk_valid,
  input logic                         coh_en,
  input logic                         lk_hit,
  input logic [$clog2(NUM_WIN)-1:0]   lk_cs,
  input logic [7:0]                   lk_attr,
  input logic [$clog2(NUM_WIN+1)-1:0] elig_cnt,
  input logic [NUM_WIN-1:0]           elig_mask,
  input logic [NUM_WIN-1:0]           hit_vec
);
  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_cs == '0 && lk_attr == 8'h00));

  // R7
  attr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($countones(lk_attr[3:0]) == 3 && lk_attr[7:5] == 3'b000));

  // R7
  coh_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_attr[4] == $past(coh_en)));

  // R9
  req_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ($past(lk_valid) && $past(hit_vec) != '0));

  // R10
  cnt_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elig_cnt == $countones(elig_mask));

  // R10
  mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && !$past(reg_wr, 2)) |-> $stable(elig_mask));

endmodule

bind dram_cs_decoder dram_cs_decoder_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .lk_valid(lk_valid),
  .coh_en(coh_en), .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_attr(lk_attr),
  .elig_cnt(elig_cnt), .elig_mask(elig_mask), .hit_vec(hit_vec)
);

// File: tb/dram_cs_decoder_tb.sv
module dram_cs_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coh_en = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, lk_valid = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, lk_addr = '0;
  logic [31:0] reg_rdata;
  logic        lk_hit;
  logic [1:0]  lk_cs;
  logic [7:0]  lk_attr;
  logic [3:0]  lk_target;
  logic [2:0]  elig_cnt;
  logic [3:0]  elig_mask;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m_place [4];
  logic [31:0] m_ext   [4];

  always #2.5 clk = ~clk;

  dram_cs_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .coh_en(coh_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_cs(lk_cs),
    .lk_attr(lk_attr), .lk_target(lk_target), .elig_cnt(elig_cnt), .elig_mask(elig_mask)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_ok(input int i);
    return m_ext[i][0] && (m_place[i][3:0] == 4'h0);
  endfunction

  // window bounds computed with 64-bit arithmetic on the granule count
  function automatic bit ref_in(input int i, input logic [31:0] a);
    longint lo, len;
    lo  = longint'(m_place[i][31:24]) * 64'd16777216;
    len = (longint'(m_ext[i][31:24]) + 1) * 64'd16777216;
    return ref_ok(i) && (longint'(a) >= lo) && (longint'(a) < lo + len);
  endfunction

  task automatic wr_reg(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = off; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    if (off < 8'h20) begin
      if (off[2]) m_ext[off[4:3]]   = d & 32'hFF00_001D;
      else        m_place[off[4:3]] = d & 32'hFF00_000F;
    end
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1; reg_addr = off;
    @(negedge clk);
    reg_rd = 0;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic elig_chk(input string req);
    logic [3:0] m; int c;
    m = '0; c = 0;
    for (int i = 0; i < 4; i++) if (ref_ok(i)) begin m[i] = 1; c++; end
    check(req, 64'(elig_mask), 64'(m));
    check(req, 64'(elig_cnt), 64'(c));
  endtask

  task automatic lk_chk(input string req, input logic [31:0] a, input logic coh, input logic v);
    logic eh; logic [1:0] ec; logic [7:0] ea;
    eh = 0; ec = 0; ea = 0;
    if (v) for (int i = 3; i >= 0; i--) if (ref_in(i, a)) begin
      eh = 1; ec = 2'(i);
      ea = (8'h0F & ~(8'h01 << i)) | (coh ? 8'h10 : 8'h00);
    end
    @(negedge clk);
    lk_valid = v; lk_addr = a; coh_en = coh;
    @(negedge clk);
    lk_valid = 0;
    check(req, {lk_hit, lk_cs, lk_attr, lk_target}, {eh, ec, ea, 4'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0042);
    for (int i = 0; i < 4; i++) begin m_place[i] = 0; m_ext[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R3 reset state
    @(negedge clk);
    elig_chk("R3");
    rd_chk("R3", 8'h04, 32'h0);
    lk_chk("R3", 32'h0000_0000, 0, 1);

    // R5 / R8 single window, edges
    wr_reg(8'h00, 32'h0000_0000);
    wr_reg(8'h04, 32'h0F00_0001);
    elig_chk("R10");
    lk_chk("R5", 32'h0FFF_FFFF, 0, 1);
    lk_chk("R8", 32'h1000_0000, 0, 1);
    // R7 coherency bit, 16 MB window
    wr_reg(8'h08, 32'h1000_0000);
    wr_reg(8'h0C, 32'h0000_0005);
    lk_chk("R7", 32'h1000_0000, 1, 1);
    lk_chk("R7", 32'h10FF_FFFF, 1, 1);
    lk_chk("R5", 32'h1100_0000, 0, 1);
    // R4 high base bits exclude window 2
    wr_reg(8'h10, 32'h2000_0001);
    wr_reg(8'h14, 32'h0F00_0009);
    elig_chk("R4");
    lk_chk("R4", 32'h2000_0000, 0, 1);
    // R6 overlap, lowest index wins; window 3 reached beyond window 0
    wr_reg(8'h18, 32'h0000_0000);
    wr_reg(8'h1C, 32'h3F00_000D);
    elig_chk("R10");
    lk_chk("R6", 32'h0500_0000, 0, 1);
    lk_chk("R6", 32'h3000_0000, 0, 1);
    // R9 no request, no hit
    lk_chk("R9", 32'h0500_0000, 0, 0);
    // R1 out-of-map write ignored, read zero; map positions
    wr_reg(8'h20, 32'hFFFF_FFFF);
    rd_chk("R1", 8'h20, 32'h0);
    rd_chk("R1", 8'h08, 32'h1000_0000);
    elig_chk("R1");
    // R2 masked fields
    wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h14, 32'hFF00_001D);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    rd_chk("R2", 8'h10, 32'hFF00_000F);
    // R5 window ending at 4 GB
    wr_reg(8'h10, 32'hF000_0000);
    wr_reg(8'h14, 32'h0F00_0001);
    lk_chk("R5", 32'hFFFF_FFFF, 1, 1);
    lk_chk("R5", 32'hEFFF_FFFF, 0, 1);

    // random programming with overlap-prone values
    for (int it = 0; it < 300; it++) begin
      int w; logic [31:0] pv, ev;
      w  = int'($urandom_range(0, 3));
      pv = {8'($urandom_range(0, 7) * 4), 20'($urandom), ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0};
      ev = {8'($urandom_range(0, 9)), 19'($urandom), 3'($urandom), 1'b0, ($urandom_range(0, 4) != 0)};
      wr_reg(8'(w * 8), pv);
      wr_reg(8'(w * 8 + 4), ev);
      elig_chk("R10");
      for (int k = 0; k < 3; k++) begin
        int j; longint lo, hi; logic [31:0] a;
        j  = int'($urandom_range(0, 3));
        lo = longint'(m_place[j][31:24]) * 64'd16777216;
        hi = lo + (longint'(m_ext[j][31:24]) + 1) * 64'd16777216;
        case ($urandom_range(0, 3))
          0: a = 32'(lo);
          1: a = 32'(hi - 1);
          2: a = 32'(hi);
          default: a = $urandom;
        endcase
        lk_chk("R6", a, 1'($urandom), 1'($urandom_range(0, 7) != 0));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule